// File: doc/BRIEF.md
# Two-Sector Outer Cache Tag and Coherence Controller

This block manages the tags and coherence state of a direct-mapped outer cache. Each line holds 128 bytes as two 64-byte halves (sectors) under a single address tag. The inner level makes 64-byte requests, so every request names exactly one sector. Each sector has its own MESI state, and a sector counts as valid whenever its state is not Invalid. Hits, fills and snoops act on one sector. Allocating a line acts on both sectors. Sector data lives in a small internal memory. Memory traffic and writebacks to memory use one 64-byte transaction per sector.

The request side and the response side are valid/ready streams. A request is taken on a cycle where `req_valid` and `req_ready` are both high. After that, `req_ready` stays low until the response has been taken, so only one operation is in flight. The response holds `rsp_valid` and all of its fields steady until `rsp_ready` is seen high. On the memory request port the block holds valid, op, address and data steady until `mem_req_ready` is high. Read, ownership and upgrade transactions are completed by a single-cycle `mem_rsp_valid` pulse. A writeback is complete at its handshake. The snoop port is also valid/ready. It is serviced only while the controller is idle, and it wins over a request that arrives in the same cycle.

Address layout: byte offset in the low log2(sector bytes) bits, then one sector-select bit, then the set index, then the tag.

Top module: `sector_cache_ctrl`

## Requirements
- R1: After reset every sector of every set is Invalid and `req_ready` is high. The first request to any set reports both sector states as Invalid (0) and is not a hit.
- R2: A read whose tag matches and whose sector is valid returns that sector's data. It issues no memory transaction and leaves the sector state unchanged.
- R3: A request whose tag matches but whose sector is Invalid issues exactly one memory fetch, at the 64-byte-aligned address of that sector. The other sector's state is not changed.
- R4: A read fetch uses op 0 (read shared). The filled sector becomes Shared (1) if `mem_rsp_shared` is high with the response, and Exclusive (2) otherwise.
- R5: A write to an Exclusive or Modified sector is done locally with no memory transaction. A write to a Shared sector first issues op 3 (upgrade). A write that misses first fetches with op 1 (read for ownership). In every case the sector ends Modified (3) and holds the written data.
- R6: On a tag mismatch, each Modified sector of the old line is written back with op 2 as its own transaction, sector 0 before sector 1, using the old tag and that sector's data. Both sectors are then invalidated and the requested sector is fetched under the new tag, so the other sector then reads as Invalid.
- R7: A snoop with kind 0 sets the addressed sector to Invalid and kind 1 sets it to Shared. A Modified sector is first written back with op 2. The other sector is unchanged. A snoop to a non-matching tag or an Invalid sector causes no memory traffic and changes nothing.
- R8: `req_ready` is low from the cycle after a request is accepted until its response is taken. `rsp_valid` and `rsp_rdata` hold while `rsp_ready` is low.
- R9: When a snoop and a request are both presented in the idle state, `req_ready` is low and `snp_ready` is high, so the snoop is taken first.
- R10: Every response reports the states of sector 0 (`rsp_st_lo`) and sector 1 (`rsp_st_hi`) as they were at lookup, before any change the request makes. `rsp_hit` is high when the tag matched and the addressed sector was valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 = sector write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the sector |
| req_wdata | input | 8*SECTOR_BYTES | Full-sector write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken when high with valid |
| rsp_rdata | output | 8*SECTOR_BYTES | Sector data after the operation |
| rsp_hit | output | 1 | Tag matched and sector was valid |
| rsp_st_lo | output | 2 | Sector 0 state at lookup (I=0,S=1,E=2,M=3) |
| rsp_st_hi | output | 2 | Sector 1 state at lookup |
| snp_valid | input | 1 | Snoop present |
| snp_ready | output | 1 | Snoop accepted when high with valid |
| snp_addr | input | ADDR_W | Snooped sector address |
| snp_kind | input | 1 | 0 = invalidate, 1 = downgrade to Shared |
| mem_req_valid | output | 1 | Memory transaction present |
| mem_req_ready | input | 1 | Memory transaction accepted |
| mem_req_op | output | 2 | 0 read shared, 1 read own, 2 writeback, 3 upgrade |
| mem_req_addr | output | ADDR_W | Sector-aligned address |
| mem_req_wdata | output | 8*SECTOR_BYTES | Writeback data |
| mem_rsp_valid | input | 1 | Completion of read, own or upgrade |
| mem_rsp_data | input | 8*SECTOR_BYTES | Fetched sector data |
| mem_rsp_shared | input | 1 | Another cache holds the sector |

## Verification
The hardest case to reach is eviction of a line whose two sectors are both Modified. Only in that case must two writebacks leave in a fixed order, each with its own data and the old tag, before the new fetch goes out. The stimulus builds this state with two write misses to the two halves of one set, then sends a read with a different tag to that set, and checks the order and contents of the captured memory log. A second hard case is a snoop and a request arriving in the same idle cycle. It is made by raising both valids on one falling edge and checking the two ready signals before the next rising edge.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_t;

  typedef enum logic [1:0] {
    MOP_RD_SH  = 2'd0,
    MOP_RD_OWN = 2'd1,
    MOP_WB     = 2'd2,
    MOP_UPG    = 2'd3
  } mop_t;

  typedef enum logic [2:0] {
    F_IDLE,
    F_LOOK,
    F_EVICT,
    F_MREQ,
    F_MWAIT,
    F_SNPWB,
    F_RESP
  } fsm_t;
endpackage

// File: rtl/sc_tag_store.sv
module sc_tag_store
  import sc_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int TAG_W = 21,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] rd_tag,
  output mesi_t [1:0]      rd_st,
  input  logic             tag_we,
  input  logic [TAG_W-1:0] tag_wd,
  input  logic [1:0]       st_we,
  input  mesi_t [1:0]      st_wd
);
  mesi_t [1:0]      st_q  [SETS];
  logic [TAG_W-1:0] tag_q [SETS];

  assign rd_tag = tag_q[idx];
  assign rd_st  = st_q[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) begin
        st_q[i][0] <= ST_I;
        st_q[i][1] <= ST_I;
      end
    end else begin
      for (int s = 0; s < 2; s++) begin
        if (st_we[s]) st_q[idx][s] <= st_wd[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tag_we) tag_q[idx] <= tag_wd;
  end

  // R6: a line takes a new tag only once both of its sectors are Invalid
  a_r6_retarget_only_free: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_we && (tag_wd != tag_q[idx])) |-> (st_q[idx][0] == ST_I && st_q[idx][1] == ST_I));
endmodule

// File: rtl/sc_data_store.sv
module sc_data_store #(
  parameter int SETS   = 16,
  parameter int DATA_W = 512,
  localparam int IDX_W = $clog2(SETS),
  localparam int DEPTH = 2 * SETS
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic              rd_sec,
  output logic [DATA_W-1:0] rd_data,
  input  logic              we,
  input  logic              wr_sec,
  input  logic [DATA_W-1:0] wd
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  assign rd_data = mem_q[{idx, rd_sec}];

  always_ff @(posedge clk) begin
    if (we) mem_q[{idx, wr_sec}] <= wd;
  end
endmodule

// File: rtl/sector_cache_ctrl.sv
module sector_cache_ctrl
  import sc_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int SETS         = 16,
  parameter int SECTOR_BYTES = 64,
  localparam int OFF_W  = $clog2(SECTOR_BYTES),
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - OFF_W - 1 - IDX_W,
  localparam int DATA_W = 8 * SECTOR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_hit,
  output logic [1:0]        rsp_st_lo,
  output logic [1:0]        rsp_st_hi,
  input  logic              snp_valid,
  output logic              snp_ready,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              snp_kind,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [1:0]        mem_req_op,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_shared
);
  localparam logic [OFF_W-1:0] ZERO_OFF = '0;

  fsm_t              fsm;
  logic [TAG_W-1:0]  l_tag;
  logic [IDX_W-1:0]  l_idx;
  logic              l_sec;
  logic              lat_snp;
  logic              lat_dg;
  logic              lat_write;
  logic [DATA_W-1:0] lat_wdata;
  mop_t              op_q;
  logic [1:0]        ev_pend;
  logic [DATA_W-1:0] rsp_data_q;
  logic              rsp_hit_q;
  mesi_t [1:0]       rsp_st_q;

  logic [TAG_W-1:0]  rd_tag;
  mesi_t [1:0]       rd_st;
  logic              tag_we;
  logic [1:0]        st_we;
  mesi_t [1:0]       st_wd;
  logic              dat_we;
  logic              dat_rd_sec;
  logic [DATA_W-1:0] dat_wd;
  logic [DATA_W-1:0] rd_data;

  mesi_t sec_st;
  logic  tag_match, hit, line_free, wb_sec;

  sc_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) tags_i (
    .clk(clk), .rst_n(rst_n), .idx(l_idx), .rd_tag(rd_tag), .rd_st(rd_st),
    .tag_we(tag_we), .tag_wd(l_tag), .st_we(st_we), .st_wd(st_wd)
  );

  sc_data_store #(.SETS(SETS), .DATA_W(DATA_W)) data_i (
    .clk(clk), .idx(l_idx), .rd_sec(dat_rd_sec), .rd_data(rd_data),
    .we(dat_we), .wr_sec(l_sec), .wd(dat_wd)
  );

  assign sec_st    = rd_st[l_sec];
  assign tag_match = (rd_tag == l_tag);
  assign hit       = tag_match && (sec_st != ST_I);
  assign line_free = (rd_st[0] == ST_I) && (rd_st[1] == ST_I);
  assign wb_sec    = !ev_pend[0];

  assign rsp_valid = (fsm == F_RESP);
  assign rsp_rdata = rsp_data_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_st_lo = rsp_st_q[0];
  assign rsp_st_hi = rsp_st_q[1];

  always_comb begin
    req_ready     = (fsm == F_IDLE) && !snp_valid;
    snp_ready     = (fsm == F_IDLE);
    mem_req_valid = 1'b0;
    mem_req_op    = MOP_RD_SH;
    mem_req_addr  = {l_tag, l_idx, l_sec, ZERO_OFF};
    mem_req_wdata = rd_data;
    tag_we        = 1'b0;
    st_we         = 2'b00;
    st_wd[0]      = ST_I;
    st_wd[1]      = ST_I;
    dat_we        = 1'b0;
    dat_wd        = lat_wdata;
    dat_rd_sec    = l_sec;
    case (fsm)
      F_LOOK: begin
        if (lat_snp) begin
          if (hit && sec_st != ST_M) begin
            st_we[l_sec] = 1'b1;
            st_wd[l_sec] = lat_dg ? ST_S : ST_I;
          end
        end else if (hit && lat_write && (sec_st == ST_E || sec_st == ST_M)) begin
          st_we[l_sec] = 1'b1;
          st_wd[l_sec] = ST_M;
          dat_we       = 1'b1;
        end
      end
      F_EVICT: begin
        if (ev_pend == 2'b00) begin
          st_we = 2'b11;
        end else begin
          mem_req_valid = 1'b1;
          mem_req_op    = MOP_WB;
          mem_req_addr  = {rd_tag, l_idx, wb_sec, ZERO_OFF};
          dat_rd_sec    = wb_sec;
        end
      end
      F_MREQ: begin
        mem_req_valid = 1'b1;
        mem_req_op    = op_q;
      end
      F_MWAIT: begin
        if (mem_rsp_valid) begin
          tag_we       = 1'b1;
          st_we[l_sec] = 1'b1;
          st_wd[l_sec] = lat_write ? ST_M : (mem_rsp_shared ? ST_S : ST_E);
          dat_we       = 1'b1;
          dat_wd       = lat_write ? lat_wdata : mem_rsp_data;
        end
      end
      F_SNPWB: begin
        mem_req_valid = 1'b1;
        mem_req_op    = MOP_WB;
        mem_req_addr  = {rd_tag, l_idx, l_sec, ZERO_OFF};
        if (mem_req_ready) begin
          st_we[l_sec] = 1'b1;
          st_wd[l_sec] = lat_dg ? ST_S : ST_I;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm        <= F_IDLE;
      l_tag      <= '0;
      l_idx      <= '0;
      l_sec      <= 1'b0;
      lat_snp    <= 1'b0;
      lat_dg     <= 1'b0;
      lat_write  <= 1'b0;
      lat_wdata  <= '0;
      op_q       <= MOP_RD_SH;
      ev_pend    <= 2'b00;
      rsp_data_q <= '0;
      rsp_hit_q  <= 1'b0;
      rsp_st_q[0] <= ST_I;
      rsp_st_q[1] <= ST_I;
    end else begin
      case (fsm)
        F_IDLE: begin
          if (snp_valid) begin
            {l_tag, l_idx, l_sec} <= snp_addr[ADDR_W-1:OFF_W];
            lat_snp <= 1'b1;
            lat_dg  <= snp_kind;
            fsm     <= F_LOOK;
          end else if (req_valid) begin
            {l_tag, l_idx, l_sec} <= req_addr[ADDR_W-1:OFF_W];
            lat_snp   <= 1'b0;
            lat_write <= req_write;
            lat_wdata <= req_wdata;
            fsm       <= F_LOOK;
          end
        end
        F_LOOK: begin
          if (lat_snp) begin
            fsm <= (hit && sec_st == ST_M) ? F_SNPWB : F_IDLE;
          end else begin
            rsp_st_q  <= rd_st;
            rsp_hit_q <= hit;
            if (hit && !lat_write) begin
              rsp_data_q <= rd_data;
              fsm        <= F_RESP;
            end else if (hit && sec_st != ST_S) begin
              rsp_data_q <= lat_wdata;
              fsm        <= F_RESP;
            end else if (hit) begin
              op_q <= MOP_UPG;
              fsm  <= F_MREQ;
            end else begin
              op_q <= lat_write ? MOP_RD_OWN : MOP_RD_SH;
              if (tag_match || line_free) begin
                fsm <= F_MREQ;
              end else begin
                ev_pend <= {rd_st[1] == ST_M, rd_st[0] == ST_M};
                fsm     <= F_EVICT;
              end
            end
          end
        end
        F_EVICT: begin
          if (ev_pend == 2'b00) fsm <= F_MREQ;
          else if (mem_req_ready) ev_pend[wb_sec] <= 1'b0;
        end
        F_MREQ:  if (mem_req_ready) fsm <= F_MWAIT;
        F_MWAIT: begin
          if (mem_rsp_valid) begin
            rsp_data_q <= lat_write ? lat_wdata : mem_rsp_data;
            fsm        <= F_RESP;
          end
        end
        F_SNPWB: if (mem_req_ready) fsm <= F_IDLE;
        F_RESP:  if (rsp_ready) fsm <= F_IDLE;
        default: fsm <= F_IDLE;
      endcase
    end
  end

  // R8: once a request is taken, no second one is taken in the next cycle
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R8: a stalled response keeps its valid and its data
  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R6: a stalled memory transaction keeps its op and address
  a_r6_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_op)));

  // R3: memory traffic is always one whole aligned sector
  a_r3_sector_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));
endmodule

// File: tb/sector_cache_ctrl_tb_top.sv
`timescale 1ns/1ps
module sector_cache_ctrl_tb_top;
  localparam int AW = 32;
  localparam int DW = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, rsp_hit;
  logic          rsp_ready = 1'b0;
  logic [DW-1:0] rsp_rdata;
  logic [1:0]    rsp_st_lo, rsp_st_hi;
  logic          snp_valid = 1'b0, snp_kind = 1'b0, snp_ready;
  logic [AW-1:0] snp_addr = '0;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [1:0]    mem_req_op;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid = 1'b0, mem_rsp_shared = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;

  int n_cmp = 0;
  int n_bad = 0;
  logic shared_cfg = 1'b0;

  logic [1:0]    lg_op   [32];
  logic [AW-1:0] lg_addr [32];
  logic [DW-1:0] lg_data [32];
  int            lg_n;
  int            pend;
  logic [AW-1:0] pend_addr;

  always #2.5 clk = ~clk;

  sector_cache_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_hit(rsp_hit), .rsp_st_lo(rsp_st_lo), .rsp_st_hi(rsp_st_hi),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_addr(snp_addr), .snp_kind(snp_kind),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_op(mem_req_op),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_shared(mem_rsp_shared)
  );

  function automatic logic [AW-1:0] mk(input int tag, input int idx, input int sec);
    logic [20:0] t = tag[20:0];
    logic [3:0]  i = idx[3:0];
    return {t, i, sec[0], 6'b0};
  endfunction

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {8{a, ~a}};
  endfunction

  function automatic logic [DW-1:0] wpat(input int k);
    return {16{32'hC0DE_0000 + k}};
  endfunction

  // memory model: accepts every other cycle, answers reads two cycles later
  always @(posedge clk) begin
    if (!rst_n) begin
      lg_n          <= 0;
      pend          <= 0;
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
    end else begin
      mem_req_ready <= mem_req_valid && !mem_req_ready;
      mem_rsp_valid <= 1'b0;
      if (pend != 0) begin
        pend <= pend - 1;
        if (pend == 1) begin
          mem_rsp_valid  <= 1'b1;
          mem_rsp_data   <= pat(pend_addr);
          mem_rsp_shared <= shared_cfg;
        end
      end
      if (mem_req_valid && mem_req_ready) begin
        lg_op[lg_n]   <= mem_req_op;
        lg_addr[lg_n] <= mem_req_addr;
        lg_data[lg_n] <= mem_req_wdata;
        lg_n          <= lg_n + 1;
        if (mem_req_op != 2'd2) begin
          pend      <= 2;
          pend_addr <= mem_req_addr;
        end
      end
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic chk_w(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  logic [DW-1:0] r_data;
  logic          r_hit;
  logic [1:0]    r_lo, r_hi;

  task automatic do_req(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input int hold);
    bit busy_ok = 1'b1;
    bit hold_ok = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rsp_ready = (hold == 0);
    while (!rsp_valid) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
    end
    r_data = rsp_rdata; r_hit = rsp_hit; r_lo = rsp_st_lo; r_hi = rsp_st_hi;
    for (int k = 0; k < hold; k++) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
      if (!rsp_valid || rsp_rdata !== r_data) hold_ok = 1'b0;
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R8 req_ready low while busy", {63'b0, busy_ok}, 64'd1);
    if (hold > 0) chk("R8 response held under stall", {63'b0, hold_ok}, 64'd1);
  endtask

  task automatic do_snoop(input logic [AW-1:0] a, input logic kind);
    @(negedge clk);
    snp_valid = 1'b1; snp_addr = a; snp_kind = kind;
    while (!snp_ready) @(negedge clk);
    @(negedge clk);
    snp_valid = 1'b0;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 req_ready after reset", {63'b0, req_ready}, 64'd1);
    chk("R1 no response after reset", {63'b0, rsp_valid}, 64'd0);
    chk("R1 no memory traffic after reset", {63'b0, mem_req_valid}, 64'd0);
  endtask

  task automatic t_first_read;
    int b = lg_n;
    shared_cfg = 1'b0;
    do_req(1'b0, mk(5, 3, 0), '0, 0);
    chk("R1 first access not hit", {63'b0, r_hit}, 64'd0);
    chk("R1 states invalid", {60'b0, r_lo, r_hi}, 64'd0);
    chk("R3 one fetch", lg_n - b, 64'd1);
    chk("R4 fetch op read shared", lg_op[b], 64'd0);
    chk("R3 fetch address", lg_addr[b], mk(5, 3, 0));
    chk_w("R4 fetched data returned", r_data, pat(mk(5, 3, 0)));
  endtask

  task automatic t_read_hit;
    int b = lg_n;
    do_req(1'b0, mk(5, 3, 0), '0, 3);
    chk("R2 hit flag", {63'b0, r_hit}, 64'd1);
    chk("R2 no memory traffic", lg_n - b, 64'd0);
    chk("R4 exclusive without sharer", {62'b0, r_lo}, 64'd2);
    chk("R10 other sector reported invalid", {62'b0, r_hi}, 64'd0);
    chk_w("R2 hit data", r_data, pat(mk(5, 3, 0)));
  endtask

  task automatic t_sector_fill;
    int b = lg_n;
    shared_cfg = 1'b1;
    do_req(1'b0, mk(5, 3, 1), '0, 0);
    chk("R3 single sector fetch", lg_n - b, 64'd1);
    chk("R3 fetch address is sector 1", lg_addr[b], mk(5, 3, 1));
    chk("R10 lookup states E/I", {60'b0, r_lo, r_hi}, {60'b0, 2'd2, 2'd0});
    do_req(1'b0, mk(5, 3, 0), '0, 0);
    chk("R3 sector 0 kept exclusive", {62'b0, r_lo}, 64'd2);
    chk("R4 shared fill", {62'b0, r_hi}, 64'd1);
    shared_cfg = 1'b0;
  endtask

  task automatic t_writes;
    int b = lg_n;
    do_req(1'b1, mk(5, 3, 0), wpat(0), 0);
    chk("R5 local write no traffic", lg_n - b, 64'd0);
    b = lg_n;
    do_req(1'b1, mk(5, 3, 1), wpat(1), 0);
    chk("R5 upgrade issued", lg_n - b, 64'd1);
    chk("R5 upgrade op", lg_op[b], 64'd3);
    chk("R5 upgrade address", lg_addr[b], mk(5, 3, 1));
    do_req(1'b0, mk(5, 3, 1), '0, 0);
    chk("R5 both sectors modified", {60'b0, r_lo, r_hi}, {60'b0, 2'd3, 2'd3});
    chk_w("R5 written data kept", r_data, wpat(1));
  endtask

  task automatic t_snoops;
    int b = lg_n;
    do_snoop(mk(5, 3, 0), 1'b1);
    chk("R7 downgrade of modified writes back", lg_n - b, 64'd1);
    chk("R7 writeback op", lg_op[b], 64'd2);
    chk("R7 writeback address", lg_addr[b], mk(5, 3, 0));
    chk_w("R7 writeback data", lg_data[b], wpat(0));
    b = lg_n;
    do_snoop(mk(7, 3, 1), 1'b0);
    chk("R7 foreign-tag snoop no traffic", lg_n - b, 64'd0);
    do_req(1'b0, mk(5, 3, 1), '0, 0);
    chk("R7 only target sector changed", {60'b0, r_lo, r_hi}, {60'b0, 2'd1, 2'd3});
    chk_w("R7 foreign snoop left data", r_data, wpat(1));
  endtask

  task automatic t_evict_one;
    int b = lg_n;
    do_req(1'b0, mk(9, 3, 0), '0, 0);
    chk("R6 writeback plus fetch", lg_n - b, 64'd2);
    chk("R6 writeback op", lg_op[b], 64'd2);
    chk("R6 old-tag writeback address", lg_addr[b], mk(5, 3, 1));
    chk_w("R6 writeback data", lg_data[b], wpat(1));
    chk("R6 new-tag fetch", lg_addr[b+1], mk(9, 3, 0));
    chk("R10 pre-eviction states", {60'b0, r_lo, r_hi}, {60'b0, 2'd1, 2'd3});
    do_req(1'b0, mk(9, 3, 1), '0, 0);
    chk("R6 other sector invalid after move", {60'b0, r_lo, r_hi}, {60'b0, 2'd2, 2'd0});
  endtask

  task automatic t_evict_two;
    int b = lg_n;
    do_req(1'b1, mk(1, 5, 1), wpat(11), 0);
    do_req(1'b1, mk(1, 5, 0), wpat(10), 0);
    chk("R5 write miss uses read-own", lg_op[b], 64'd1);
    chk("R5 write miss sector 0 read-own", lg_op[b+1], 64'd1);
    b = lg_n;
    do_req(1'b0, mk(2, 5, 1), '0, 0);
    chk("R6 two writebacks and fetch", lg_n - b, 64'd3);
    chk("R6 sector 0 first", lg_addr[b], mk(1, 5, 0));
    chk_w("R6 sector 0 data", lg_data[b], wpat(10));
    chk("R6 sector 1 second", lg_addr[b+1], mk(1, 5, 1));
    chk_w("R6 sector 1 data", lg_data[b+1], wpat(11));
    chk("R6 fetch last", {lg_op[b+2], lg_addr[b+2]}, {2'd0, mk(2, 5, 1)});
  endtask

  task automatic t_snoop_inval_m;
    int b;
    do_req(1'b1, mk(2, 5, 1), wpat(20), 0);
    b = lg_n;
    do_snoop(mk(2, 5, 1), 1'b0);
    chk("R7 invalidate of modified writes back", lg_n - b, 64'd1);
    chk_w("R7 invalidate writeback data", lg_data[b], wpat(20));
    do_req(1'b0, mk(2, 5, 1), '0, 0);
    chk("R7 sector invalid after snoop", {61'b0, r_hit, r_hi}, 64'd0);
  endtask

  task automatic t_priority;
    int b = lg_n;
    @(negedge clk);
    snp_valid = 1'b1; snp_addr = mk(1, 8, 0); snp_kind = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = mk(1, 8, 0);
    #0.5;
    chk("R9 request held off by snoop", {63'b0, req_ready}, 64'd0);
    chk("R9 snoop accepted", {63'b0, snp_ready}, 64'd1);
    @(negedge clk);
    snp_valid = 1'b0;
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    chk("R7 snoop to invalid line no traffic", lg_n - b, 64'd0);
    do_req(1'b0, mk(1, 8, 0), '0, 0);
    chk("R9 request served after snoop", lg_n - b, 64'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_read();
    t_read_hit();
    t_sector_fill();
    t_writes();
    t_snoops();
    t_evict_one();
    t_evict_two();
    t_snoop_inval_m();
    t_priority();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule